// File: doc/BRIEF.md
# Automatic Fine Tuning Voltage Controller

This block holds a tuner on the carrier of a received channel. It watches two digitised levels. The first is a signal-present level that reads high when a valid transmission is detected. The second is the level of the fine-tuning discriminator, which sits mid-scale when the tuner is on frequency. The block moves a tuning-voltage word one step at a time until the discriminator level falls inside a target window. The word feeds an external DAC or PWM stage, which produces the tuner's control voltage.

A programmable divider paces the steps so the analog filter after the DAC can settle between corrections. The word is kept inside a capture range around the most recently loaded preset. A preset port writes a stored channel setting and recentres that range on it. The locked output reports that the discriminator has stayed in the window for a programmable number of consecutive evaluations. Monitoring never stops, so any later drift is corrected.

Top module: `aft_tuner`

## Requirements
- R1: After reset, `tune_word` equals parameter RST_WORD, `locked` is 0, and the capture range is RST_WORD minus RST_SPAN to RST_WORD plus RST_SPAN, clipped to 0 and 2^TW-1.
- R2: While `ident_lvl` is below 219, the word holds its value. `locked` is 0 from the next cycle on.
- R3: When `ident_lvl` is at or above 219 and `afts_lvl` is above 153 at an evaluation tick, the word increases by exactly 1.
- R4: When `ident_lvl` is at or above 219 and `afts_lvl` is below 102 at an evaluation tick, the word decreases by exactly 1.
- R5: When `ident_lvl` is at or above 219 and `afts_lvl` is from 102 to 153 inclusive, the word holds its value.
- R6: An evaluation tick occurs every `tick_div`+1 cycles, counted from reset or from a load. The word never changes between ticks, and never by more than 1 at a tick.
- R7: The word never moves below the lower range limit or above the upper range limit, and it never wraps.
- R8: A cycle with `load_en` high puts `load_word` on `tune_word` at the next edge. It sets the range to `load_word` minus `span` to `load_word` plus `span`, clipped to 0 and 2^TW-1. It clears `locked` and the in-window streak, and it restarts the tick divider.
- R9: `locked` rises at the tick that completes `lock_need` consecutive in-window ticks with the signal present. A `lock_need` of 0 counts as 1. An out-of-window tick clears `locked` and the streak, and correction resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ident_lvl | input | AW | Digitised signal-present level |
| afts_lvl | input | AW | Digitised fine-tuning discriminator level |
| tick_div | input | PW | Evaluation period minus one, in cycles |
| lock_need | input | LW | In-window ticks required before lock |
| span | input | TW | Half-width of the capture range set on load |
| load_en | input | 1 | Write a preset tuning word |
| load_word | input | TW | Preset tuning word |
| tune_word | output | TW | Tuning-voltage word to the DAC |
| locked | output | 1 | Tuner is on frequency |

## Verification
The bench builds the block with a 6-bit tuning word, a 4-bit divider and a 3-bit lock count. This makes both clamp limits reachable in a few steps and keeps the word's full range small enough to observe. With the 8-bit level width, every discriminator code is swept against signal-present codes on both sides of the 219 threshold, after a fresh preset each time. This covers every edge of the window. Longer runs exercise a divider of 3, saturation at 0 and 63, a narrow range, and locking with counts of 0 and 3 followed by drift and by loss of signal.

// File: rtl/aft_tuner.sv
module aft_tuner #(
  parameter int TW = 10,
  parameter int AW = 8,
  parameter int PW = 12,
  parameter int LW = 4,
  parameter int LO_CODE = 102,
  parameter int HI_CODE = 153,
  parameter int ID_CODE = 219,
  parameter int RST_WORD = 512,
  parameter int RST_SPAN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ident_lvl,
  input  logic [AW-1:0] afts_lvl,
  input  logic [PW-1:0] tick_div,
  input  logic [LW-1:0] lock_need,
  input  logic [TW-1:0] span,
  input  logic          load_en,
  input  logic [TW-1:0] load_word,
  output logic [TW-1:0] tune_word,
  output logic          locked
);
  localparam int MAXW = (1 << TW) - 1;
  localparam int RLO  = (RST_WORD > RST_SPAN) ? RST_WORD - RST_SPAN : 0;
  localparam int RHI  = (RST_WORD + RST_SPAN > MAXW) ? MAXW : RST_WORD + RST_SPAN;

  logic [PW-1:0] cnt;
  logic [LW-1:0] streak;
  logic [TW-1:0] lo_lim, hi_lim;

  wire sig_ok   = ident_lvl >= AW'(ID_CODE);
  wire too_high = afts_lvl > AW'(HI_CODE);
  wire too_low  = afts_lvl < AW'(LO_CODE);
  wire tick     = cnt == tick_div;

  wire [LW-1:0] need    = (lock_need == '0) ? LW'(1) : lock_need;
  wire [LW:0]   streak1 = {1'b0, streak} + 1'b1;
  wire [TW:0]   up_sum  = {1'b0, load_word} + {1'b0, span};
  wire [TW-1:0] new_lo  = (load_word > span) ? load_word - span : '0;
  wire [TW-1:0] new_hi  = up_sum[TW] ? {TW{1'b1}} : up_sum[TW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      tune_word <= TW'(RST_WORD);
      lo_lim    <= TW'(RLO);
      hi_lim    <= TW'(RHI);
      streak    <= '0;
      locked    <= 1'b0;
    end else if (load_en) begin
      cnt       <= '0;
      tune_word <= load_word;
      lo_lim    <= new_lo;
      hi_lim    <= new_hi;
      streak    <= '0;
      locked    <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (!sig_ok) begin
        streak <= '0;
        locked <= 1'b0;
      end else if (tick) begin
        if (too_high) begin
          streak <= '0;
          locked <= 1'b0;
          if (tune_word < hi_lim) tune_word <= tune_word + 1'b1;
        end else if (too_low) begin
          streak <= '0;
          locked <= 1'b0;
          if (tune_word > lo_lim) tune_word <= tune_word - 1'b1;
        end else begin
          if (streak != need) streak <= streak + 1'b1;
          if (streak1 >= {1'b0, need}) locked <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aft_tuner_chk.sv
module aft_tuner_chk #(
  parameter int TW = 10,
  parameter int AW = 8,
  parameter int LO_CODE = 102,
  parameter int HI_CODE = 153,
  parameter int ID_CODE = 219
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ident_lvl,
  input logic [AW-1:0] afts_lvl,
  input logic          load_en,
  input logic [TW-1:0] load_word,
  input logic [TW-1:0] tune_word,
  input logic          locked,
  input logic [TW-1:0] lo_lim,
  input logic [TW-1:0] hi_lim
);
  p_hold_nosig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && ident_lvl < AW'(ID_CODE)) |=> $stable(tune_word));

  p_unlock_nosig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_lvl < AW'(ID_CODE)) |=> !locked);

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ((tune_word == $past(tune_word)) ||
                  ({1'b0, tune_word} == {1'b0, $past(tune_word)} + 1'b1) ||
                  ({1'b0, tune_word} + 1'b1 == {1'b0, $past(tune_word)})));

  p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_word >= lo_lim) && (tune_word <= hi_lim));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (tune_word == $past(load_word)) && !locked);

  p_lock_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(afts_lvl) >= AW'(LO_CODE)) && ($past(afts_lvl) <= AW'(HI_CODE))
                      && ($past(ident_lvl) >= AW'(ID_CODE)));
endmodule

bind aft_tuner aft_tuner_chk #(
  .TW(TW), .AW(AW), .LO_CODE(LO_CODE), .HI_CODE(HI_CODE), .ID_CODE(ID_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ident_lvl(ident_lvl), .afts_lvl(afts_lvl),
  .load_en(load_en), .load_word(load_word), .tune_word(tune_word),
  .locked(locked), .lo_lim(lo_lim), .hi_lim(hi_lim)
);

// File: tb/aft_tuner_tb.sv
module aft_tuner_tb_top;
  localparam int TW = 6, AW = 8, PW = 4, LW = 3;
  localparam int RST_WORD = 32, RST_SPAN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ident_lvl = '0, afts_lvl = '0;
  logic [PW-1:0] tick_div = '0;
  logic [LW-1:0] lock_need = 3'd3;
  logic [TW-1:0] span = 6'd8;
  logic load_en = 1'b0;
  logic [TW-1:0] load_word = '0;
  logic [TW-1:0] tune_word;
  logic locked;

  int total = 0, bad = 0;
  int m_word, m_lo, m_hi, m_cnt, m_streak;
  bit m_lock;
  string ctx = "";

  always #10 clk = ~clk;

  aft_tuner #(.TW(TW), .AW(AW), .PW(PW), .LW(LW),
              .RST_WORD(RST_WORD), .RST_SPAN(RST_SPAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ident_lvl(ident_lvl), .afts_lvl(afts_lvl),
    .tick_div(tick_div), .lock_need(lock_need), .span(span),
    .load_en(load_en), .load_word(load_word),
    .tune_word(tune_word), .locked(locked));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    string wtag, ltag;
    int need;
    bit tick;
    @(posedge clk);
    need = (lock_need == 0) ? 1 : int'(lock_need);
    tick = (m_cnt == int'(tick_div));
    if (load_en) begin
      wtag = "R8"; ltag = "R8";
      m_word = load_word;
      m_lo = (int'(load_word) > int'(span)) ? load_word - span : 0;
      m_hi = (load_word + span > 63) ? 63 : load_word + span;
      m_cnt = 0; m_streak = 0; m_lock = 0;
    end else begin
      m_cnt = tick ? 0 : m_cnt + 1;
      ltag = "R9";
      if (ident_lvl < 219) begin
        wtag = "R2"; ltag = "R2";
        m_streak = 0; m_lock = 0;
      end else if (!tick) begin
        wtag = "R6";
      end else if (afts_lvl > 153) begin
        wtag = "R3"; m_streak = 0; m_lock = 0;
        if (m_word < m_hi) m_word++;
      end else if (afts_lvl < 102) begin
        wtag = "R4"; m_streak = 0; m_lock = 0;
        if (m_word > m_lo) m_word--;
      end else begin
        wtag = "R5";
        if (m_streak != need) m_streak++;
        if (m_streak >= need) m_lock = 1;
      end
    end
    if (ctx != "") wtag = ctx;
    @(negedge clk);
    chk(wtag, int'(tune_word), m_word);
    chk(ltag, int'(locked), int'(m_lock));
  endtask

  task automatic do_load(input int w, input int s);
    load_word = TW'(w); span = TW'(s); load_en = 1'b1;
    step();
    load_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idv[5] = '{0, 100, 218, 219, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_word = RST_WORD; m_lo = RST_WORD - RST_SPAN; m_hi = RST_WORD + RST_SPAN;
    m_cnt = 0; m_streak = 0; m_lock = 0;
    chk("R1", int'(tune_word), RST_WORD);
    chk("R1", int'(locked), 0);

    // R1 range: eight raises reach 40 and stop there
    ident_lvl = 8'd255; afts_lvl = 8'd200; ctx = "R1";
    for (int i = 0; i < 10; i++) step();
    chk("R1", int'(tune_word), 40);
    ctx = "";

    // sweep of every discriminator code against signal-present codes, fresh preset each time
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < 256; a++) begin
        ident_lvl = 8'd0; afts_lvl = 8'd0;
        do_load(32, 8);
        ident_lvl = AW'(idv[k]); afts_lvl = AW'(a);
        step();
      end
    end

    // R7 clamps at the top of the word, the bottom and a narrow range
    ident_lvl = 8'd255; afts_lvl = 8'd250; ctx = "R7";
    do_load(60, 8);
    for (int i = 0; i < 8; i++) step();
    chk("R7", int'(tune_word), 63);
    afts_lvl = 8'd5;
    do_load(3, 8);
    for (int i = 0; i < 8; i++) step();
    chk("R7", int'(tune_word), 0);
    afts_lvl = 8'd154;
    do_load(20, 4);
    for (int i = 0; i < 9; i++) step();
    chk("R7", int'(tune_word), 24);
    afts_lvl = 8'd101;
    for (int i = 0; i < 12; i++) step();
    chk("R7", int'(tune_word), 16);
    ctx = "";

    // R6 pacing with a divider of 3: one step per four cycles
    tick_div = 4'd3; afts_lvl = 8'd180;
    do_load(30, 20);
    for (int i = 0; i < 16; i++) step();
    chk("R6", int'(tune_word), 34);
    afts_lvl = 8'd40;
    for (int i = 0; i < 9; i++) step();
    tick_div = 4'd0;

    // R9 lock after three in-window ticks, drift, then loss of signal
    lock_need = 3'd3; afts_lvl = 8'd128;
    do_load(30, 10);
    step(); step();
    chk("R9", int'(locked), 0);
    step();
    chk("R9", int'(locked), 1);
    step(); step();
    afts_lvl = 8'd160; step();
    chk("R9", int'(locked), 0);
    chk("R9", int'(tune_word), 31);
    afts_lvl = 8'd102; for (int i = 0; i < 4; i++) step();
    chk("R9", int'(locked), 1);
    ident_lvl = 8'd218; step();
    chk("R2", int'(locked), 0);
    ident_lvl = 8'd255; afts_lvl = 8'd153; lock_need = 3'd0;
    step();
    chk("R9", int'(locked), 1);
    lock_need = 3'd7; afts_lvl = 8'd100; step();
    afts_lvl = 8'd120;
    for (int i = 0; i < 9; i++) step();

    // R8 load in a locked state with a divider running
    tick_div = 4'd2;
    do_load(50, 63);
    chk("R8", int'(tune_word), 50);
    afts_lvl = 8'd255;
    for (int i = 0; i < 60; i++) step();
    chk("R8", int'(tune_word), 63);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule